// File: doc/BRIEF.md
# Line Transmit Delay Aligner

This block sets the transmit bit timing of a basic-rate line transceiver working as a terminal. A one-cycle pulse marks each received frame start. The block then counts oscillator periods and raises a transmit frame strobe at a fixed lag after that pulse. The lag is two line bits less seven oscillator periods. With the default 7.68 MHz oscillator and 40 periods per line bit, this comes to 73 periods.

External line circuitry adds delay in both directions. A compensation input shortens the lag by two more periods, which is roughly 260 ns, giving 71. This keeps the total input-to-output phase deviation inside the allowed window of -7% to +15% of one line bit. The compensation input is read only on the cycle that carries the received frame-start pulse, so a frame already in flight keeps the lag it started with.

Once a transmit frame has started, the block emits a bit strobe every 40 oscillator periods. The first bit strobe falls on the same cycle as the frame strobe. Each new transmit frame strobe restarts this bit phase.

Top module: `tx_delay_aligner`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that until the first received frame-start pulse, both strobes stay low. A reset taken during a countdown cancels the pending frame strobe.
- R2: With `comp_en` low at the edge that samples `rx_frame_start`, `tx_frame_strobe` is high exactly 73 clock edges after that edge (2 x 40 - 7).
- R3: With `comp_en` high at the edge that samples `rx_frame_start`, the lag is 71 edges (73 - 2).
- R4: `comp_en` is sampled only together with a frame-start pulse. Changing it during a countdown leaves the pending lag unchanged, and the new value applies from the next frame-start pulse.
- R5: `tx_frame_strobe` is high for exactly one clock cycle per received frame-start pulse that completes its countdown.
- R6: A frame-start pulse that arrives during a countdown restarts it. Only one frame strobe results, and it lags the latest pulse.
- R7: `tx_bit_strobe` is high in the cycle of every `tx_frame_strobe`, and after that once every 40 cycles.
- R8: A new transmit frame strobe resets the bit phase, whatever the phase of the running bit count was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local oscillator clock (7.68 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_frame_start | input | 1 | One-cycle pulse marking a received frame boundary |
| comp_en | input | 1 | Shortens the transmit lag by two oscillator periods |
| tx_frame_strobe | output | 1 | One-cycle pulse at the transmit frame start |
| tx_bit_strobe | output | 1 | One-cycle pulse at each transmit bit boundary |

## Verification
The hardest case to reach is a new transmit frame that lands in the middle of a running bit period. Old and new bit phases must then be told apart. To get there, the stimulus waits for a bit strobe, waits 15 more cycles, and then sends a frame-start pulse. The new frame therefore begins 8 cycles into a bit period of the old phase. A second hard case is a frame-start pulse that arrives while a countdown is still pending. The stimulus does this by issuing two pulses 30 cycles apart. A third case toggles `comp_en` during a countdown to confirm that the pending lag holds.

// File: rtl/tda_pkg.sv
// Package: shared timing defaults for the transmit delay aligner.
// Assumes an oscillator of 40 periods per line bit (7.68 MHz, 192 kbit/s).
package tda_pkg;
    localparam int unsigned DEF_BIT_OSC   = 40; // oscillator periods per line bit
    localparam int unsigned DEF_LEAD_BITS = 2;  // whole line bits of transmit lag
    localparam int unsigned DEF_GUARD_OSC = 7;  // periods removed from the lag
    localparam int unsigned DEF_COMP_OSC  = 2;  // extra periods removed when compensating

    // Nominal lag in oscillator periods.
    function automatic int unsigned lag_nominal(int unsigned bit_osc,
                                                int unsigned lead_bits,
                                                int unsigned guard_osc);
        return bit_osc * lead_bits - guard_osc;
    endfunction
endpackage

// File: rtl/tda_offset_sel.sv
// Module: picks the transmit lag in oscillator periods from the compensation
// input. Purely combinational. Assumes the nominal lag minus the
// compensation is at least 2, so the countdown always has a whole cycle.
module tda_offset_sel #(
    parameter int unsigned BIT_OSC   = tda_pkg::DEF_BIT_OSC,
    parameter int unsigned LEAD_BITS = tda_pkg::DEF_LEAD_BITS,
    parameter int unsigned GUARD_OSC = tda_pkg::DEF_GUARD_OSC,
    parameter int unsigned COMP_OSC  = tda_pkg::DEF_COMP_OSC,
    parameter int unsigned CNT_W     = 7
) (
    input  logic             comp_en,
    output logic [CNT_W-1:0] lag_o
);
    localparam int unsigned LAG_NOM   = tda_pkg::lag_nominal(BIT_OSC, LEAD_BITS, GUARD_OSC);
    localparam int unsigned LAG_SHORT = LAG_NOM - COMP_OSC;
    localparam logic [CNT_W-1:0] NOM_V   = CNT_W'(LAG_NOM);
    localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(LAG_SHORT);

    generate
        if (COMP_OSC == 0) begin : g_fixed
            // Selection: no compensation configured, lag is fixed.
            assign lag_o = NOM_V;
        end else begin : g_select
            // Selection: shortened lag when compensation is requested.
            always_comb lag_o = comp_en ? SHORT_V : NOM_V;
        end
    endgenerate
endmodule

// File: rtl/tda_lag_counter.sv
// Module: counts the selected lag down from each received frame start and
// raises a one-cycle frame strobe when it expires. A new frame start always
// reloads the count, even one that arrives while a count is pending.
// Assumes lag_i >= 2 and that lag_i is meaningful only while rx_sof is high.
module tda_lag_counter #(
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_sof,
    input  logic [CNT_W-1:0] lag_i,
    output logic             fire_now,
    output logic             fire_o
);
    logic [CNT_W-1:0] cnt;
    logic             armed;

    // Expiry: the edge that raises the strobe (a frame start wins over it).
    always_comb fire_now = armed && !rx_sof && (cnt == CNT_W'(1));

    // Countdown: load on frame start, count down while armed, fire at expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            armed  <= 1'b0;
            fire_o <= 1'b0;
        end else begin
            fire_o <= fire_now;
            if (rx_sof) begin
                cnt   <= lag_i;
                armed <= 1'b1;
            end else if (armed) begin
                cnt <= cnt - CNT_W'(1);
                if (cnt == CNT_W'(1)) armed <= 1'b0;
            end
        end
    end

    // Checker state: edges since the last frame start and the lag latched then.
    localparam int unsigned SW = CNT_W + 1;
    logic [SW-1:0]    since_sof;
    logic [CNT_W-1:0] lat_lag;
    logic             seen_sof;

    // Checker bookkeeping: saturating edge count since the last frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_sof <= '0;
            lat_lag   <= '0;
            seen_sof  <= 1'b0;
        end else if (rx_sof) begin
            since_sof <= '0;
            lat_lag   <= lag_i;
            seen_sof  <= 1'b1;
        end else if (since_sof != {SW{1'b1}}) begin
            since_sof <= since_sof + SW'(1);
        end
    end

    p_lag_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> (since_sof == {1'b0, lat_lag}))
        else $error("frame strobe off its latched lag");

    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o)
        else $error("frame strobe wider than one cycle");

    p_needs_sof_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> seen_sof)
        else $error("frame strobe without a prior frame start");
endmodule

// File: rtl/tda_bit_timer.sv
// Module: produces a bit strobe on the transmit frame start and then every
// BIT_OSC cycles. A frame start restarts the phase. The timer stays idle
// until the first frame start after reset.
module tda_bit_timer #(
    parameter int unsigned BIT_OSC = tda_pkg::DEF_BIT_OSC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic bit_o
);
    localparam int unsigned BW = $clog2(BIT_OSC);
    localparam logic [BW-1:0] RELOAD = BW'(BIT_OSC - 1);

    logic [BW-1:0] cnt;
    logic          running;

    // Bit pacing: restart on frame start, otherwise count periods to the next bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
            bit_o   <= 1'b0;
        end else if (start_i) begin
            cnt     <= RELOAD;
            running <= 1'b1;
            bit_o   <= 1'b1;
        end else if (running && cnt == '0) begin
            cnt   <= RELOAD;
            bit_o <= 1'b1;
        end else begin
            bit_o <= 1'b0;
            if (running) cnt <= cnt - BW'(1);
        end
    end

    // Checker state: cycles since the last bit strobe, and a restart flag.
    localparam int unsigned GW = $clog2(BIT_OSC + 1) + 1;
    logic [GW-1:0] gap;
    logic          restart_q;

    // Checker bookkeeping: gap between strobes, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap       <= '0;
            restart_q <= 1'b0;
        end else begin
            restart_q <= start_i;
            if (bit_o) gap <= GW'(1);
            else if (gap != {GW{1'b1}}) gap <= gap + GW'(1);
        end
    end

    p_bit_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_o && !restart_q) |-> (gap == GW'(BIT_OSC)))
        else $error("bit strobe spacing wrong");

    p_phase_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart_q |-> bit_o)
        else $error("bit phase not restarted at frame start");
endmodule

// File: rtl/tx_delay_aligner.sv
// Module: top of the transmit delay aligner. Places the transmit frame start
// at a programmable lag after each received frame start, and paces transmit
// bits from it. Assumes rx_frame_start is a one-cycle pulse in the clk domain.
module tx_delay_aligner #(
    parameter int unsigned BIT_OSC   = tda_pkg::DEF_BIT_OSC,
    parameter int unsigned LEAD_BITS = tda_pkg::DEF_LEAD_BITS,
    parameter int unsigned GUARD_OSC = tda_pkg::DEF_GUARD_OSC,
    parameter int unsigned COMP_OSC  = tda_pkg::DEF_COMP_OSC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_frame_start,
    input  logic comp_en,
    output logic tx_frame_strobe,
    output logic tx_bit_strobe
);
    localparam int unsigned CNT_W = $clog2(BIT_OSC * LEAD_BITS + 1);

    logic [CNT_W-1:0] lag_sel;
    logic             fire_now;

    tda_offset_sel #(
        .BIT_OSC(BIT_OSC), .LEAD_BITS(LEAD_BITS),
        .GUARD_OSC(GUARD_OSC), .COMP_OSC(COMP_OSC), .CNT_W(CNT_W)
    ) u_sel (
        .comp_en (comp_en),
        .lag_o   (lag_sel)
    );

    tda_lag_counter #(.CNT_W(CNT_W)) u_lag (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_sof   (rx_frame_start),
        .lag_i    (lag_sel),
        .fire_now (fire_now),
        .fire_o   (tx_frame_strobe)
    );

    tda_bit_timer #(.BIT_OSC(BIT_OSC)) u_bit (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (fire_now),
        .bit_o   (tx_bit_strobe)
    );

    p_bit_on_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_frame_strobe |-> tx_bit_strobe)
        else $error("frame strobe without bit strobe");
endmodule

// File: tb/tx_delay_aligner_tb.sv
`timescale 1ns/1ps
module tx_delay_aligner_tb;
    localparam int BIT = 40, NOM = 73, SHORT = 71;

    logic clk = 1'b0, rst_n = 1'b0, rx = 1'b0, comp = 1'b0;
    logic frame, bitq;

    always #2.5 clk = ~clk;

    tx_delay_aligner u_dut (
        .clk(clk), .rst_n(rst_n), .rx_frame_start(rx), .comp_en(comp),
        .tx_frame_strobe(frame), .tx_bit_strobe(bitq)
    );

    int vecs = 0, miss = 0, cyc = 0;
    int m_lag = -1, m_bit = -1;
    logic e_frame, e_bit;
    int last_rx = -1, last_frame = -1, last_bit = -1, prev_bit = -1;
    int nframes = 0, nbits = 0;
    bit done = 0;

    task automatic chk(string tag, int got, int exp, string what);
        vecs++;
        if (got !== exp) begin
            miss++;
            $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", tag, what, got, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    endtask

    // Reference model, compared just after every rising edge.
    always begin
        @(posedge clk);
        #1;
        cyc++;
        e_frame = 1'b0;
        e_bit   = 1'b0;
        if (!rst_n) begin
            m_lag = -1;
            m_bit = -1;
        end else begin
            if (rx) m_lag = comp ? SHORT : NOM;
            else if (m_lag > 0) begin
                m_lag--;
                if (m_lag == 0) begin e_frame = 1'b1; m_lag = -1; end
            end
            if (e_frame) begin m_bit = BIT; e_bit = 1'b1; end
            else if (m_bit > 0) begin
                m_bit--;
                if (m_bit == 0) begin e_bit = 1'b1; m_bit = BIT; end
            end
        end
        chk("R5", int'(frame), int'(e_frame), "frame strobe vs model");
        chk("R7", int'(bitq), int'(e_bit), "bit strobe vs model");
        if (rx && rst_n) last_rx = cyc;
        if (frame) begin last_frame = cyc; nframes++; end
        if (bitq) begin prev_bit = last_bit; last_bit = cyc; nbits++; end
        if (cyc > 20000 && !done) begin
            miss++;
            vecs++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    task automatic pulse();
        @(negedge clk) rx = 1'b1;
        @(negedge clk) rx = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int n0, b0, f2;
        idle(3);
        chk("R1", int'(frame), 0, "frame during reset");
        chk("R1", int'(bitq), 0, "bit during reset");
        @(negedge clk) rst_n = 1'b1;
        idle(100);
        chk("R1", nframes, 0, "frames before first start");
        chk("R1", nbits, 0, "bits before first start");

        comp = 1'b0; pulse(); idle(80);
        chk("R2", last_frame - last_rx, NOM, "nominal lag");
        chk("R2", nframes, 1, "frame count");

        comp = 1'b1; pulse(); idle(80);
        chk("R3", last_frame - last_rx, SHORT, "compensated lag");

        comp = 1'b0; pulse(); idle(20);
        comp = 1'b1; idle(60);
        chk("R4", last_frame - last_rx, NOM, "mid-frame compensation change ignored");
        pulse(); idle(80);
        chk("R4", last_frame - last_rx, SHORT, "change applied at next start");

        comp = 1'b0; n0 = nframes;
        pulse(); idle(30); pulse(); idle(80);
        chk("R6", nframes - n0, 1, "restart yields one strobe");
        chk("R6", last_frame - last_rx, NOM, "lag from latest start");

        idle(200);
        chk("R7", last_bit - prev_bit, BIT, "bit spacing");
        chk("R7", (last_bit - last_frame) % BIT, 0, "bits aligned to frame");

        @(negedge clk);
        while (!bitq) @(negedge clk);
        idle(15); pulse();
        idle(75);
        f2 = last_frame;
        chk("R8", f2 - last_rx, NOM, "new frame lag");
        idle(90);
        chk("R8", last_bit - f2, 2 * BIT, "bit phase from new frame");
        chk("R8", last_bit - prev_bit, BIT, "spacing after restart");

        pulse(); idle(10);
        @(negedge clk) rst_n = 1'b0;
        idle(2);
        @(negedge clk) rst_n = 1'b1;
        n0 = nframes; b0 = nbits;
        idle(150);
        chk("R1", nframes - n0, 0, "reset cancels pending frame");
        chk("R1", nbits - b0, 0, "bits idle after reset");

        done = 1;
        finish_run();
    end
endmodule